// File: doc/BRIEF.md
# Thread-Seeded Global-History Branch Predictor

This block is the conditional branch predictor of one processing unit in a chip that runs the threads of a single program speculatively on several units. It uses a global-history scheme. A history shift register selects a 2-bit saturating counter in a pattern table, and the upper bit of that counter gives the predicted direction. Each resolved branch trains the counter that was used for its prediction and shifts its outcome into the history.

The history is not carried over from one thread to the next. When the unit begins a thread, a shared store outside this block supplies the history of that static thread, and the block loads it. When the thread is squashed and restarted, the store supplies the latest committed history, and the block reloads it. This discards everything the squashed run shifted in. When the thread completes, the block presents its history and the thread identifier so that the store can be updated.

The history register is `HIST_W` bits wide, 14 by default. The table holds 2^`PHT_IDX_W` counters and is indexed by the low `PHT_IDX_W` bits of the history. A full-size build sets `PHT_IDX_W` equal to `HIST_W`, which gives 16K counters, or 4 KB. The default of 11 keeps elaboration small.

Top module: `ltp_predictor`

## Requirements
- R1: After reset the history is all zeros, every counter holds 1 (weakly not-taken), and `pred_valid` and `wb_valid` are low.
- R2: A request in cycle N produces `pred_valid` high in cycle N+1, with `pred_idx` equal to the low `PHT_IDX_W` history bits as they stood in cycle N. `pred_taken` is bit 1 of the counter at that index. Without a request, `pred_valid` is low in the next cycle.
- R3: Counters are 2-bit saturating. A taken update increments the counter up to 3 and a not-taken update decrements it down to 0. The value 3 stays at 3 on taken, and 0 stays at 0 on not-taken.
- R4: An update trains the counter selected by `upd_idx`, not the one selected by the current history.
- R5: Each update with no load in the same cycle shifts `upd_taken` into history bit 0 and drops the top bit. With neither an update nor a load, the history holds its value.
- R6: `start_valid` writes `start_hist` into the history register.
- R7: `restart_valid` writes `restart_hist` into the history register. When both start and restart are asserted, the restart value wins.
- R8: A start or restart in the same cycle as an update replaces the history, so the outcome is not shifted in. The counter at `upd_idx` is still trained.
- R9: `end_valid` in cycle N gives `wb_valid`, `wb_tid` = `end_tid`, and `wb_hist` in cycle N+1. `wb_hist` is the history after that cycle's update shift and ignores any load in the same cycle.
- R10: When a request and an update fall on the same counter in one cycle, the prediction uses the counter value from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_req | input | 1 | Prediction request |
| pred_valid | output | 1 | Prediction result valid (one cycle after request) |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_idx | output | PHT_IDX_W | Table index used; returned later on the update port |
| upd_valid | input | 1 | Resolved branch outcome valid |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_idx | input | PHT_IDX_W | Index saved from the prediction |
| start_valid | input | 1 | Thread start: load history |
| start_hist | input | HIST_W | History of the starting thread |
| restart_valid | input | 1 | Thread restart after squash: reload history |
| restart_hist | input | HIST_W | Latest committed history of the thread |
| end_valid | input | 1 | Thread completion |
| end_tid | input | TID_W | Static thread identifier of the completing thread |
| wb_valid | output | 1 | Writeback of history valid |
| wb_tid | output | TID_W | Thread identifier for the writeback |
| wb_hist | output | HIST_W | History to store for that thread |

## Verification
Three kinds of event can fall in the same cycle: a history load or reload, a resolved branch, and a thread completion. A prediction read can also hit the same counter that an update is writing. Directed phases drive each of these pairings together: start with restart, load with update, completion with both load and update, and request with an update to the same index. A random phase then mixes all ports freely. A behavioural model in the bench decides each outcome from the priorities in R7 to R10, and every output is compared with it on every cycle.

// File: rtl/ltp_pkg.sv
package ltp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'd1;
  localparam ctr_t CTR_MAX  = 2'd3;
  localparam ctr_t CTR_MIN  = 2'd0;

  // Next value of a saturating counter for one resolved outcome.
  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    if (taken) return (c == CTR_MAX) ? c : c + 2'd1;
    else       return (c == CTR_MIN) ? c : c - 2'd1;
  endfunction

  // Direction encoded by a counter.
  function automatic logic ctr_dir(input ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/ltp_ctr_table.sv
module ltp_ctr_table
  import ltp_pkg::*;
#(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_taken,
  output logic [IDX_W-1:0] rd_idx_q,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem [DEPTH];

  // Named internal events for checking
  ctr_t ctr_old;
  ctr_t ctr_new;
  ctr_t rd_ctr;
  logic same_slot;

  assign ctr_old   = mem[wr_idx];
  assign ctr_new   = ctr_step(ctr_old, wr_taken);
  assign rd_ctr    = mem[rd_idx];
  assign same_slot = rd_en && wr_en && (rd_idx == wr_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
      rd_valid <= 1'b0;
      rd_taken <= 1'b0;
      rd_idx_q <= '0;
    end else begin
      if (wr_en) mem[wr_idx] <= ctr_new;
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_taken <= ctr_dir(rd_ctr);
        rd_idx_q <= rd_idx;
      end
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_valid && rd_idx_q == $past(rd_idx))); // R2
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid); // R2
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && ctr_old == CTR_MAX) |=> (mem[$past(wr_idx)] == CTR_MAX)); // R3
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && ctr_old == CTR_MIN) |=> (mem[$past(wr_idx)] == CTR_MIN)); // R3
  AST_READ_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    same_slot |=> (rd_taken == $past(ctr_old[1]))); // R10
endmodule

// File: rtl/ltp_hist_ctl.sv
module ltp_hist_ctl #(
  parameter int HIST_W = 14,
  parameter int IDX_W  = 11,
  parameter int TID_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  input  logic              start_valid,
  input  logic [HIST_W-1:0] start_hist,
  input  logic              restart_valid,
  input  logic [HIST_W-1:0] restart_hist,
  input  logic              end_valid,
  input  logic [TID_W-1:0]  end_tid,
  output logic [IDX_W-1:0]  hist_idx,
  output logic              wb_valid,
  output logic [TID_W-1:0]  wb_tid,
  output logic [HIST_W-1:0] wb_hist
);
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_shifted;
  logic [HIST_W-1:0] load_val;
  logic              load_evt;

  // Outcome-only view of the history for this cycle
  assign hist_shifted = shift_en ? {hist_q[HIST_W-2:0], shift_bit} : hist_q;
  // Restart carries committed history and outranks a fresh start
  assign load_evt     = start_valid || restart_valid;
  assign load_val     = restart_valid ? restart_hist : start_hist;
  assign hist_idx     = hist_q[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q   <= '0;
      wb_valid <= 1'b0;
      wb_tid   <= '0;
      wb_hist  <= '0;
    end else begin
      hist_q   <= load_evt ? load_val : hist_shifted;
      wb_valid <= end_valid;
      if (end_valid) begin
        wb_tid  <= end_tid;
        wb_hist <= hist_shifted;
      end
    end
  end

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && !restart_valid) |=> (hist_q == $past(start_hist))); // R6
  AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    restart_valid |=> (hist_q == $past(restart_hist))); // R7
  AST_LOAD_OVER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && !restart_valid && shift_en) |=> (hist_q == $past(start_hist))); // R8
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_evt) |=>
      (hist_q[0] == $past(shift_bit) && hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !load_evt) |=> $stable(hist_q)); // R5
  AST_WB_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    end_valid |=> (wb_valid && wb_tid == $past(end_tid))); // R9
  AST_WB_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (end_valid && !shift_en) |=> (wb_hist == $past(hist_q))); // R9
endmodule

// File: rtl/ltp_predictor.sv
module ltp_predictor #(
  parameter int HIST_W    = 14,
  parameter int PHT_IDX_W = 11,
  parameter int TID_W     = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pred_req,
  output logic                 pred_valid,
  output logic                 pred_taken,
  output logic [PHT_IDX_W-1:0] pred_idx,
  input  logic                 upd_valid,
  input  logic                 upd_taken,
  input  logic [PHT_IDX_W-1:0] upd_idx,
  input  logic                 start_valid,
  input  logic [HIST_W-1:0]    start_hist,
  input  logic                 restart_valid,
  input  logic [HIST_W-1:0]    restart_hist,
  input  logic                 end_valid,
  input  logic [TID_W-1:0]     end_tid,
  output logic                 wb_valid,
  output logic [TID_W-1:0]     wb_tid,
  output logic [HIST_W-1:0]    wb_hist
);
  logic [PHT_IDX_W-1:0] hist_idx;

  ltp_hist_ctl #(
    .HIST_W (HIST_W),
    .IDX_W  (PHT_IDX_W),
    .TID_W  (TID_W)
  ) u_hist (
    .clk           (clk),
    .rst_n         (rst_n),
    .shift_en      (upd_valid),
    .shift_bit     (upd_taken),
    .start_valid   (start_valid),
    .start_hist    (start_hist),
    .restart_valid (restart_valid),
    .restart_hist  (restart_hist),
    .end_valid     (end_valid),
    .end_tid       (end_tid),
    .hist_idx      (hist_idx),
    .wb_valid      (wb_valid),
    .wb_tid        (wb_tid),
    .wb_hist       (wb_hist)
  );

  ltp_ctr_table #(
    .IDX_W (PHT_IDX_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (pred_req),
    .rd_idx   (hist_idx),
    .rd_valid (pred_valid),
    .rd_taken (pred_taken),
    .rd_idx_q (pred_idx),
    .wr_en    (upd_valid),
    .wr_idx   (upd_idx),
    .wr_taken (upd_taken)
  );
endmodule

// File: tb/ltp_predictor_tb_top.sv
module ltp_predictor_tb_top;
  localparam int HW = 14;
  localparam int IW = 11;
  localparam int TW = 11;
  localparam int HMASK = (1 << HW) - 1;
  localparam int IMASK = (1 << IW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pred_req = 1'b0, upd_valid = 1'b0, upd_taken = 1'b0;
  logic start_valid = 1'b0, restart_valid = 1'b0, end_valid = 1'b0;
  logic [IW-1:0] upd_idx = '0;
  logic [HW-1:0] start_hist = '0, restart_hist = '0;
  logic [TW-1:0] end_tid = '0;
  logic pred_valid, pred_taken, wb_valid;
  logic [IW-1:0] pred_idx;
  logic [TW-1:0] wb_tid;
  logic [HW-1:0] wb_hist;

  always #2 clk = ~clk;

  ltp_predictor dut_i (
    .clk(clk), .rst_n(rst_n),
    .pred_req(pred_req), .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_idx(pred_idx),
    .upd_valid(upd_valid), .upd_taken(upd_taken), .upd_idx(upd_idx),
    .start_valid(start_valid), .start_hist(start_hist),
    .restart_valid(restart_valid), .restart_hist(restart_hist),
    .end_valid(end_valid), .end_tid(end_tid),
    .wb_valid(wb_valid), .wb_tid(wb_tid), .wb_hist(wb_hist)
  );

  // Behavioural reference state
  int m_hist;
  int m_ctr [0:(1<<IW)-1];
  int e_pv, e_pt, e_pi, e_wv, e_wt, e_wh;
  int checks = 0;
  int fails = 0;
  string tag = "R1";

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("pred_valid", int'(pred_valid), e_pv);
    if (e_pv != 0) begin
      chk("pred_idx", int'(pred_idx), e_pi);
      chk("pred_taken", int'(pred_taken), e_pt);
    end
    chk("wb_valid", int'(wb_valid), e_wv);
    if (e_wv != 0) begin
      chk("wb_tid", int'(wb_tid), e_wt);
      chk("wb_hist", int'(wb_hist), e_wh);
    end
  endtask

  // One cycle: check previous result, drive new inputs, advance the model.
  task automatic cyc(input bit pr, input bit uv, input bit ut, input int ui,
                     input bit sv, input int sh, input bit rv, input int rh,
                     input bit ev, input int et);
    int shifted;
    compare();
    pred_req = pr; upd_valid = uv; upd_taken = ut; upd_idx = ui[IW-1:0];
    start_valid = sv; start_hist = sh[HW-1:0];
    restart_valid = rv; restart_hist = rh[HW-1:0];
    end_valid = ev; end_tid = et[TW-1:0];
    // prediction reads the counter before this cycle's training (R10)
    e_pv = pr ? 1 : 0;
    if (pr) begin
      e_pi = m_hist & IMASK;
      e_pt = (m_ctr[e_pi] >= 2) ? 1 : 0;
    end
    if (uv) begin
      int u = ui & IMASK;
      if (ut) m_ctr[u] = (m_ctr[u] == 3) ? 3 : m_ctr[u] + 1;
      else    m_ctr[u] = (m_ctr[u] == 0) ? 0 : m_ctr[u] - 1;
    end
    shifted = uv ? (((m_hist << 1) | (ut ? 1 : 0)) & HMASK) : m_hist;
    e_wv = ev ? 1 : 0;
    if (ev) begin
      e_wt = et & ((1 << TW) - 1);
      e_wh = shifted;
    end
    if (rv)      m_hist = rh & HMASK;
    else if (sv) m_hist = sh & HMASK;
    else         m_hist = shifted;
    @(negedge clk);
  endtask

  task automatic idle(); cyc(0,0,0,0, 0,0, 0,0, 0,0); endtask
  task automatic peek(input int tid); cyc(1,0,0,0, 0,0, 0,0, 1,tid); endtask

  initial begin
    repeat (500000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_hist = 0;
    for (int i = 0; i < (1 << IW); i++) m_ctr[i] = 1;
    e_pv = 0; e_pt = 0; e_pi = 0; e_wv = 0; e_wt = 0; e_wh = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, history zero, counters weakly not-taken
    tag = "R1";
    peek(3); peek(4); idle();

    // R3: saturate counter at index 5 up then down, history held at 5
    tag = "R3";
    cyc(0,0,0,0, 1,5, 0,0, 0,0);
    for (int k = 0; k < 5; k++) cyc(1,1,1,5, 1,5, 0,0, 0,0);
    for (int k = 0; k < 6; k++) cyc(1,1,0,5, 1,5, 0,0, 0,0);
    cyc(1,1,1,5, 1,5, 0,0, 0,0); peek(1);

    // R4: training uses upd_idx, not the live history
    tag = "R4";
    cyc(0,0,0,0, 1,9, 0,0, 0,0);
    cyc(1,1,1,200, 1,9, 0,0, 0,0);
    cyc(1,1,1,200, 1,9, 0,0, 0,0);
    cyc(0,0,0,0, 1,200, 0,0, 0,0);
    peek(2); peek(2);

    // R5: outcomes shift into bit 0, idle holds
    tag = "R5";
    cyc(0,0,0,0, 1,16'h2abc, 0,0, 0,0);
    cyc(0,1,1,7, 0,0, 0,0, 0,0);
    cyc(0,1,0,7, 0,0, 0,0, 0,0);
    cyc(0,1,1,7, 0,0, 0,0, 0,0);
    idle(); idle(); peek(6); idle();

    // R6: start load
    tag = "R6";
    cyc(0,0,0,0, 1,12'h3c3, 0,0, 0,0); peek(11); idle();

    // R7: restart reload, and restart over start in one cycle
    tag = "R7";
    cyc(0,0,0,0, 0,0, 1,16'h1555, 0,0); peek(12);
    cyc(0,0,0,0, 1,16'h0aaa, 1,16'h3001, 0,0); peek(13); idle();

    // R8: load beside an update: history replaced, counter still trained
    tag = "R8";
    cyc(0,1,1,33, 1,33, 0,0, 0,0);
    cyc(1,1,1,33, 0,0, 1,33, 0,0);
    peek(14); idle();

    // R9: completion with update and load in the same cycle
    tag = "R9";
    cyc(0,0,0,0, 1,16'h2001, 0,0, 0,0);
    cyc(0,1,1,0, 1,16'h0077, 0,0, 1,TW'(1500));
    cyc(0,0,0,0, 0,0, 0,0, 1,77);
    peek(2047); idle();

    // R10: request and update on the same counter
    tag = "R10";
    cyc(0,0,0,0, 1,40, 0,0, 0,0);
    cyc(1,1,1,40, 1,40, 0,0, 0,0);
    cyc(1,1,1,40, 1,40, 0,0, 0,0);
    cyc(1,1,0,40, 1,40, 0,0, 0,0);
    cyc(1,0,0,0, 0,0, 0,0, 0,0); idle();

    // R2: random mix of every port, checked every cycle
    tag = "R2";
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom;
      cyc(r[0], r[1] | r[2], r[3], $urandom & IMASK,
          (r[7:4] == 0), $urandom & HMASK, (r[11:8] == 0), $urandom & HMASK,
          (r[14:12] == 0), $urandom & ((1 << TW) - 1));
    end
    idle(); idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule